// File: doc/BRIEF.md
# Programmable Down-Counting Timer with Bus Register Interface

This block is a single down-counting timer reached through an APB slave port. Software programs a reload value, selects one of two modes and turns the counter on. Once running, the counter loses one per clock. When it passes through zero it raises an interrupt flag. In periodic mode it then restarts from the programmed reload value. In free-running mode it restarts from all ones.

The interrupt flag stays set until software reads one of two clear locations. One is the per-timer clear register and the other is the global clear register. A mask bit in the control register hides the flag from the interrupt pin and from the masked status views. The raw status view always shows the flag. The usual software sequence is to turn the counter off, write the reload value and turn the counter back on, because turning it on is what copies the reload value into the counter.

Top module: `tick_timer_apb`

## Requirements
- R1: After reset the control register, the counter and the interrupt flag are all zero, and `timer_irq` is low.
- R2: When the enable bit changes from 0 to 1, the counter takes the reload value (offset 0x00) on the next clock. On each clock after that it decreases by one, and its live value reads at offset 0x04.
- R3: In periodic mode (control bit 1 = 1), a counter at zero reloads the programmed value on the next clock. This gives a period of reload+1 cycles, and that reload cycle sets the interrupt flag.
- R4: In free-running mode (control bit 1 = 0), a counter at zero goes to 0xFFFF_FFFF on the next clock, and that cycle sets the interrupt flag.
- R5: While the enable bit is 0 the counter holds its value. Writing a new reload value while disabled leaves the current value unchanged.
- R6: Bit 0 of offset 0xA8 shows the raw flag whatever the mask. Bit 0 of offsets 0x10 and 0xA0, and the `timer_irq` pin, show the flag AND NOT the mask bit (control bit 2).
- R7: A read of offset 0x0C or 0xA4 returns zero and clears the flag, unless an expiry happens on the same cycle, in which case the flag stays set. These reads do not disturb the counter.
- R8: Control at offset 0x08 holds enable in bit 0, mode in bit 1 and mask in bit 2. These bits read back, and all higher bits read as zero.
- R9: Writes to offsets 0x04, 0x10, 0xA0, 0xA8 and 0xAC have no effect. Unmapped offsets read as zero, `pready` is always 1 and `pslverr` is always 0.
- R10: Offset 0xAC returns the `VERSION` parameter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Clock for the bus and the counter |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase indicator |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | ADDR_W | Byte offset of the register |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid during the access phase |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always zero |
| timer_irq | output | 1 | Masked interrupt, active high |

## Verification
The assertions assume that every bus transfer has a one-cycle setup phase followed by a one-cycle access phase. They also assume that `penable` is never high without `psel`, so each read of a clear register counts as exactly one clear. The stimulus drives every transfer through two tasks that keep to this shape and return the bus to idle between transfers. The bench predicts the counter from the clock cycle on which enable took effect. It sweeps small reload values in both modes, so that reload and wrap happen many times within a short run. It places clear reads only at cycles where no expiry can coincide.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Register byte offsets; software decodes these, so they are fixed
    localparam int unsigned OFS_LOAD  = 'h00;
    localparam int unsigned OFS_CUR   = 'h04;
    localparam int unsigned OFS_CTRL  = 'h08;
    localparam int unsigned OFS_EOI   = 'h0C;
    localparam int unsigned OFS_STAT  = 'h10;
    localparam int unsigned OFS_GSTAT = 'hA0;
    localparam int unsigned OFS_GEOI  = 'hA4;
    localparam int unsigned OFS_GRAW  = 'hA8;
    localparam int unsigned OFS_VER   = 'hAC;

    // Control bit positions
    localparam int unsigned BIT_EN   = 0;
    localparam int unsigned BIT_MODE = 1;
    localparam int unsigned BIT_MASK = 2;

    typedef struct packed {
        logic mask;
        logic periodic;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rstn,
    input  logic             en,
    input  logic             periodic,
    input  logic [CNT_W-1:0] load,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             en_prev;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       start;
    logic       at_zero;

    always_comb begin
        st_d         = st_q;
        st_d.en_prev = en;
        start        = en && !st_q.en_prev;
        at_zero      = (st_q.cnt == '0);
        expire       = 1'b0;
        if (start) begin
            st_d.cnt = load;
        end else if (en) begin
            if (at_zero) begin
                expire   = 1'b1;
                st_d.cnt = periodic ? load : '1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rstn) begin
        if (!rstn) st_q <= '0;
        else       st_q <= st_d;
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
    input  logic clk,
    input  logic rstn,
    input  logic expire,
    input  logic clear,
    input  logic mask,
    output logic raw,
    output logic irq
);

    typedef struct packed {
        logic flag;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a new expiry outranks a clear in the same cycle
        if (expire)     st_d.flag = 1'b1;
        else if (clear) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rstn) begin
        if (!rstn) st_q <= '0;
        else       st_q <= st_d;
    end

    assign raw = st_q.flag;
    assign irq = st_q.flag && !mask;

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int               DATA_W  = 32,
    parameter int               CNT_W   = 32,
    parameter int               ADDR_W  = 8,
    parameter logic [DATA_W-1:0] VERSION = 32'h0001_0200
) (
    input  logic              clk,
    input  logic              rstn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              raw,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  load,
    output logic              eoi_rd,
    output logic [DATA_W-1:0] prdata
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] load;
    } reg_state_t;

    reg_state_t        st_d, st_q;
    logic              wr_acc, rd_acc;
    logic              hit_load, hit_cur, hit_ctrl, hit_eoi, hit_stat;
    logic              hit_gstat, hit_geoi, hit_graw, hit_ver;
    logic              masked;
    logic [DATA_W-1:0] cnt_ext, load_ext, ctrl_ext;

    always_comb begin
        hit_load  = (paddr == ADDR_W'(OFS_LOAD));
        hit_cur   = (paddr == ADDR_W'(OFS_CUR));
        hit_ctrl  = (paddr == ADDR_W'(OFS_CTRL));
        hit_eoi   = (paddr == ADDR_W'(OFS_EOI));
        hit_stat  = (paddr == ADDR_W'(OFS_STAT));
        hit_gstat = (paddr == ADDR_W'(OFS_GSTAT));
        hit_geoi  = (paddr == ADDR_W'(OFS_GEOI));
        hit_graw  = (paddr == ADDR_W'(OFS_GRAW));
        hit_ver   = (paddr == ADDR_W'(OFS_VER));
    end

    always_comb begin
        wr_acc = psel && penable && pwrite;
        rd_acc = psel && penable && !pwrite;
        st_d   = st_q;
        if (wr_acc && hit_ctrl) begin
            st_d.ctrl.en       = pwdata[BIT_EN];
            st_d.ctrl.periodic = pwdata[BIT_MODE];
            st_d.ctrl.mask     = pwdata[BIT_MASK];
        end
        if (wr_acc && hit_load) begin
            st_d.load = pwdata[CNT_W-1:0];
        end
        eoi_rd = rd_acc && (hit_eoi || hit_geoi);
    end

    always_ff @(posedge clk or negedge rstn) begin
        if (!rstn) st_q <= '0;
        else       st_q <= st_d;
    end

    always_comb begin
        cnt_ext                  = '0;
        cnt_ext[CNT_W-1:0]       = cnt;
        load_ext                 = '0;
        load_ext[CNT_W-1:0]      = st_q.load;
        ctrl_ext                 = '0;
        ctrl_ext[BIT_EN]         = st_q.ctrl.en;
        ctrl_ext[BIT_MODE]       = st_q.ctrl.periodic;
        ctrl_ext[BIT_MASK]       = st_q.ctrl.mask;
        masked                   = raw && !st_q.ctrl.mask;
        prdata                   = '0;
        if (rd_acc) begin
            if (hit_load)                   prdata = load_ext;
            else if (hit_cur)               prdata = cnt_ext;
            else if (hit_ctrl)              prdata = ctrl_ext;
            else if (hit_stat || hit_gstat) prdata[0] = masked;
            else if (hit_graw)              prdata[0] = raw;
            else if (hit_ver)               prdata = VERSION;
        end
    end

    assign ctrl = st_q.ctrl;
    assign load = st_q.load;

endmodule

// File: rtl/tick_timer_apb.sv
module tick_timer_apb
    import tmr_pkg::*;
#(
    parameter int               DATA_W  = 32,
    parameter int               CNT_W   = 32,
    parameter int               ADDR_W  = 8,
    parameter logic [DATA_W-1:0] VERSION = 32'h0001_0200
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              timer_irq
);

    ctrl_t            ctrl;
    logic             ctrl_en, ctrl_per, ctrl_mask;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt_val;
    logic             expire;
    logic             eoi_rd;
    logic             raw_flag;

    assign ctrl_en   = ctrl.en;
    assign ctrl_per  = ctrl.periodic;
    assign ctrl_mask = ctrl.mask;

    tmr_regs #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .VERSION(VERSION)
    ) u_regs (
        .clk    (pclk),
        .rstn   (presetn),
        .psel   (psel),
        .penable(penable),
        .pwrite (pwrite),
        .paddr  (paddr),
        .pwdata (pwdata),
        .cnt    (cnt_val),
        .raw    (raw_flag),
        .ctrl   (ctrl),
        .load   (load_val),
        .eoi_rd (eoi_rd),
        .prdata (prdata)
    );

    tmr_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk     (pclk),
        .rstn    (presetn),
        .en      (ctrl_en),
        .periodic(ctrl_per),
        .load    (load_val),
        .cnt     (cnt_val),
        .expire  (expire)
    );

    tmr_irq u_irq (
        .clk   (pclk),
        .rstn  (presetn),
        .expire(expire),
        .clear (eoi_rd),
        .mask  (ctrl_mask),
        .raw   (raw_flag),
        .irq   (timer_irq)
    );

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rstn,
    input logic             en,
    input logic             periodic,
    input logic [CNT_W-1:0] load,
    input logic [CNT_W-1:0] cnt,
    input logic             raw,
    input logic             eoi_rd
);

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstn)
        !en |=> $stable(cnt)); // R5

    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rstn)
        $rose(en) |=> cnt == $past(load)); // R2

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rstn)
        (en && $past(en) && cnt != '0) |=> cnt == $past(cnt) - 1'b1); // R2

    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rstn)
        (en && $past(en) && cnt == '0 && !periodic) |=> (cnt == '1 && raw)); // R4

    AST_PERIODIC_WRAP: assert property (@(posedge clk) disable iff (!rstn)
        (en && $past(en) && cnt == '0 && periodic) |=> (cnt == $past(load) && raw)); // R3

    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rstn)
        (eoi_rd && cnt != '0) |=> !raw); // R7

endmodule

bind tick_timer_apb tmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (pclk),
    .rstn    (presetn),
    .en      (ctrl_en),
    .periodic(ctrl_per),
    .load    (load_val),
    .cnt     (cnt_val),
    .raw     (raw_flag),
    .eoi_rd  (eoi_rd)
);

// File: tb/sim_tick_timer_apb.sv
`timescale 1ns/1ps
module sim_tick_timer_apb;

    localparam logic [31:0] VER = 32'h0001_0200;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, timer_irq;
    int          cyc = 0;
    int          n_chk = 0, n_err = 0;
    bit          done = 0;

    tick_timer_apb u0 (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .timer_irq(timer_irq)
    );

    always #5 pclk = ~pclk;
    always @(posedge pclk) cyc <= cyc + 1;

    // counter value after posedge r, enabled at posedge e with reload l
    function automatic logic [31:0] model(int l, bit per, int e, int r);
        int n = r - (e + 1);
        if (per) return 32'(l - (n % (l + 1)));
        if (n <= l) return 32'(l - n);
        return 32'hFFFF_FFFF - 32'(n - l - 1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d, output int e);
        @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge pclk); penable = 1; e = cyc + 1;
        @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] d, output int r);
        @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge pclk); penable = 1; #1; d = prdata; r = cyc;
        @(negedge pclk); psel = 0; penable = 0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge pclk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d, held;
        int r, e, en_e, ed;
        repeat (3) @(negedge pclk);
        presetn = 1;

        // R1 reset state
        chk("R1 irq", {31'b0, timer_irq}, 0);
        apb_rd(8'h08, d, r); chk("R1 ctrl", d, 0);
        apb_rd(8'h04, d, r); chk("R1 count", d, 0);
        apb_rd(8'hA8, d, r); chk("R1 raw", d, 0);
        apb_rd(8'hAC, d, r); chk("R10 version", d, VER);
        chk("R9 pready", {31'b0, pready}, 1);
        chk("R9 pslverr", {31'b0, pslverr}, 0);

        // R3 periodic sweep over small reload values
        for (int l = 0; l <= 6; l++) begin
            apb_wr(8'h08, 0, e);
            apb_rd(8'h0C, d, r); chk("R7 eoi data", d, 0);
            apb_rd(8'hA8, d, r); chk("R7 cleared", d, 0);
            apb_wr(8'h00, 32'(l), e);
            apb_wr(8'h08, 3, en_e);
            for (int k = 0; k < 3; k++) begin
                apb_rd(8'h04, d, r); chk("R3 R2 periodic count", d, model(l, 1, en_e, r));
            end
            while (cyc < en_e + 2 + l) @(negedge pclk);
            apb_rd(8'hA8, d, r); chk("R3 flag set", d, 1);
        end

        // R4 free-running wrap
        apb_wr(8'h08, 0, e);
        apb_rd(8'h0C, d, r);
        apb_wr(8'h00, 3, e);
        apb_wr(8'h08, 1, en_e);
        for (int k = 0; k < 3; k++) begin
            apb_rd(8'h04, d, r); chk("R4 free count", d, model(3, 0, en_e, r));
        end
        apb_rd(8'hA8, d, r); chk("R4 flag raw", d, 1);
        apb_rd(8'h10, d, r); chk("R6 masked stat", d, 1);
        apb_rd(8'hA0, d, r); chk("R6 global stat", d, 1);
        chk("R6 irq pin", {31'b0, timer_irq}, 1);

        // R6 masking, R8 readback
        apb_wr(8'h08, 5, e);
        apb_rd(8'h08, d, r); chk("R8 ctrl readback", d, 5);
        apb_rd(8'h10, d, r); chk("R6 masked off", d, 0);
        apb_rd(8'hA0, d, r); chk("R6 global masked off", d, 0);
        apb_rd(8'hA8, d, r); chk("R6 raw ignores mask", d, 1);
        chk("R6 irq masked", {31'b0, timer_irq}, 0);

        // R7 clear by read, counting undisturbed
        apb_rd(8'h0C, d, r); chk("R7 eoi data", d, 0);
        apb_rd(8'hA8, d, r); chk("R7 raw cleared", d, 0);
        apb_rd(8'h04, d, r); chk("R7 count undisturbed", d, model(3, 0, en_e, r));

        // R5 hold while disabled
        apb_wr(8'h08, 4, ed);
        held = model(3, 0, en_e, ed);
        apb_rd(8'h04, d, r); chk("R5 held", d, held);
        repeat (4) @(negedge pclk);
        apb_rd(8'h04, d, r); chk("R5 still held", d, held);
        apb_wr(8'h00, 77, e);
        apb_rd(8'h04, d, r); chk("R5 load write no effect", d, held);
        apb_rd(8'h00, d, r); chk("R2 load readback", d, 77);

        // R2 re-enable loads new value
        apb_wr(8'h08, 3, en_e);
        apb_rd(8'h04, d, r); chk("R2 reload on enable", d, model(77, 1, en_e, r));

        // R9 read-only writes and unmapped reads
        apb_wr(8'h04, 32'h1234, e);
        apb_wr(8'hA8, 1, e);
        apb_wr(8'hAC, 0, e);
        apb_wr(8'h10, 1, e);
        apb_rd(8'h04, d, r); chk("R9 count unaffected", d, model(77, 1, en_e, r));
        apb_rd(8'hA8, d, r); chk("R9 raw unaffected", d, 0);
        apb_rd(8'hAC, d, r); chk("R9 R10 version unaffected", d, VER);
        apb_rd(8'h14, d, r); chk("R9 unmapped", d, 0);
        apb_rd(8'h40, d, r); chk("R9 unmapped", d, 0);
        apb_rd(8'hFC, d, r); chk("R9 unmapped", d, 0);

        // R7 global clear after the first periodic expiry
        while (cyc < en_e + 79) @(negedge pclk);
        chk("R3 irq after expiry", {31'b0, timer_irq}, 1);
        apb_rd(8'hA0, d, r); chk("R6 global stat set", d, 1);
        apb_rd(8'hA4, d, r); chk("R7 global eoi data", d, 0);
        apb_rd(8'hA8, d, r); chk("R7 global clear", d, 0);
        chk("R7 irq low", {31'b0, timer_irq}, 0);
        apb_rd(8'h04, d, r); chk("R7 count after clear", d, model(77, 1, en_e, r));

        // R8 upper control bits
        apb_wr(8'h08, 32'hFFFF_FFF8, e);
        apb_rd(8'h08, d, r); chk("R8 upper bits zero", d, 0);

        finish_run();
    end

endmodule